// File: doc/BRIEF.md
# Stack and Data-Memory Instruction Decoder

This block decodes the five instructions that reach the data memory and a small hardware return stack: memory read, memory write, push register, pop into register and push immediate. It takes one 16-bit instruction word and produces, in the same cycle, the strobes for the memory port and the stack. It also produces the register-file controls: which register drives the bus onto the stack, and which register is loaded from the stack. For a push of an immediate it produces the immediate value, zero-extended to the data width.

The encoding is nibble-oriented. The opcode sits in the upper bits. A register number or an 8-bit immediate sits in a fixed nibble position below it. Some low nibbles are don't-care. When a pop targets the program counter register, the block raises a separate flag. The sequencer uses that flag to let the next instruction execute before the jump takes effect. Every other instruction word, including ALU, move and branch words, leaves all outputs inactive. This lets the block's outputs be OR-ed with the controls from the other decoders.

Top module: `sd_stackmem_decode`

## Requirements
- R1: The word 0x7000 (and only that exact word) asserts `rd_en_o`, and every other output stays inactive.
- R2: The word 0x7100 (and only that exact word) asserts `wr_en_o`, and every other output stays inactive.
- R3: A word whose bits 15:8 are 0x80 and whose bits 7:4 are nonzero asserts `push_o` and `src_oe_o`, with `src_sel_o` equal to bits 7:4. Bits 3:0 have no effect on any output.
- R4: A word whose bits 15:4 are 0x900 and whose bits 3:0 are nonzero asserts `pop_o` and `dst_ld_o`, with `dst_sel_o` equal to bits 3:0.
- R5: A word whose bits 15:12 are 0xA asserts `push_o` and `imm_en_o`, with `imm_o` equal to bits 11:4 zero-extended to 16 bits (0 is a valid immediate). Bits 3:0 have no effect, and `src_oe_o` stays low.
- R6: `pc_pop_o` is high exactly when a valid pop (R4) names register `PC_REG` (default 1), and is low for every other word.
- R7: A push-register or pop word whose register field is 0 is invalid, and drives every output inactive.
- R8: Every word matching none of R1 to R5 drives all outputs inactive. This includes near misses such as 0x7001, 0x7200, 0x8130 and 0x9010.
- R9: At most one of `rd_en_o`, `wr_en_o`, `push_o`, `pop_o` is high. `src_sel_o`, `dst_sel_o` and `imm_o` are zero whenever their enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word to decode |
| rd_en_o | output | 1 | Data-memory read strobe |
| wr_en_o | output | 1 | Data-memory write strobe |
| push_o | output | 1 | Stack push strobe |
| pop_o | output | 1 | Stack pop strobe |
| src_oe_o | output | 1 | Source register drives the bus |
| src_sel_o | output | 4 | Source register number |
| dst_ld_o | output | 1 | Destination register loads from the bus |
| dst_sel_o | output | 4 | Destination register number |
| imm_en_o | output | 1 | Immediate drives the bus |
| imm_o | output | 16 | Zero-extended immediate |
| pc_pop_o | output | 1 | Pop into program counter (delayed branch) |

## Verification
The stimulus covers the two exact memory words and several values of each field-carrying pattern. It also includes near misses that differ from a valid word by one nibble, and these separate a full-word compare from a partial one.

Every low nibble is swept under a fixed push and a fixed immediate push, which shows that the don't-care nibble is truly ignored. Every destination number is swept under pop, which isolates the program-counter flag to one register and shows that field 0 is rejected. All-zero, all-ones and unrelated opcodes confirm that foreign instructions leave the block silent.

// File: rtl/sd_pkg.sv
package sd_pkg;
   localparam int unsigned INSTR_W = 16;

   localparam logic [15:0] OPC_MEM_RD   = 16'h7000;
   localparam logic [15:0] OPC_MEM_WR   = 16'h7100;
   localparam logic [7:0]  OPC_PUSH_HI  = 8'h80;
   localparam logic [11:0] OPC_POP_HI   = 12'h900;
   localparam logic [3:0]  OPC_PUSHI_HI = 4'hA;

   typedef enum logic [2:0] {
      OPK_NONE  = 3'd0,
      OPK_RD    = 3'd1,
      OPK_WR    = 3'd2,
      OPK_PUSH  = 3'd3,
      OPK_POP   = 3'd4,
      OPK_PUSHI = 3'd5
   } op_kind_e;
endpackage

// File: rtl/sd_opclass.sv
module sd_opclass
   import sd_pkg::*;
(
   input  logic [INSTR_W-1:0] instr_i,
   output op_kind_e           kind_o
);
   logic src_nz, dst_nz;

   assign src_nz = |instr_i[7:4];
   assign dst_nz = |instr_i[3:0];

   always_comb begin
      kind_o = OPK_NONE;
      if (instr_i == OPC_MEM_RD)
         kind_o = OPK_RD;
      else if (instr_i == OPC_MEM_WR)
         kind_o = OPK_WR;
      else if (instr_i[15:8] == OPC_PUSH_HI && src_nz)
         kind_o = OPK_PUSH;
      else if (instr_i[15:4] == OPC_POP_HI && dst_nz)
         kind_o = OPK_POP;
      else if (instr_i[15:12] == OPC_PUSHI_HI)
         kind_o = OPK_PUSHI;
   end
endmodule

// File: rtl/sd_regfield.sv
module sd_regfield
   import sd_pkg::*;
#(
   parameter int unsigned REG_W  = 4,
   parameter int unsigned PC_REG = 1
) (
   input  op_kind_e         kind_i,
   input  logic [REG_W-1:0] src_fld_i,
   input  logic [REG_W-1:0] dst_fld_i,
   output logic             src_oe_o,
   output logic [REG_W-1:0] src_sel_o,
   output logic             dst_ld_o,
   output logic [REG_W-1:0] dst_sel_o,
   output logic             pc_hit_o
);
   localparam logic [REG_W-1:0] PC_NUM = REG_W'(PC_REG);

   always_comb begin
      src_oe_o  = (kind_i == OPK_PUSH);
      dst_ld_o  = (kind_i == OPK_POP);
      src_sel_o = src_oe_o ? src_fld_i : '0;
      dst_sel_o = dst_ld_o ? dst_fld_i : '0;
      pc_hit_o  = dst_ld_o && (dst_fld_i == PC_NUM);
   end
endmodule

// File: rtl/sd_immext.sv
module sd_immext #(
   parameter int unsigned IMM_W  = 8,
   parameter int unsigned DATA_W = 16
) (
   input  logic              en_i,
   input  logic [IMM_W-1:0]  fld_i,
   output logic [DATA_W-1:0] imm_o
);
   logic [IMM_W-1:0] gated;

   assign gated = en_i ? fld_i : '0;

   generate
      if (DATA_W == IMM_W) begin : g_same
         assign imm_o = gated;
      end else begin : g_pad
         assign imm_o = {{(DATA_W-IMM_W){1'b0}}, gated};
      end
   endgenerate
endmodule

// File: rtl/sd_stackmem_decode.sv
module sd_stackmem_decode
   import sd_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned REG_W   = 4,
   parameter int unsigned IMM_W   = 8,
   parameter int unsigned IMM_LSB = 4,
   parameter int unsigned PC_REG  = 1
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic               rd_en_o,
   output logic               wr_en_o,
   output logic               push_o,
   output logic               pop_o,
   output logic               src_oe_o,
   output logic [REG_W-1:0]   src_sel_o,
   output logic               dst_ld_o,
   output logic [REG_W-1:0]   dst_sel_o,
   output logic               imm_en_o,
   output logic [DATA_W-1:0]  imm_o,
   output logic               pc_pop_o
);
   localparam int unsigned SRC_LSB = 4;
   localparam int unsigned DST_LSB = 0;
   localparam int unsigned PC_MAX  = (1 << REG_W) - 1;

   generate
      if (IMM_W > DATA_W) begin : g_bad_imm
         $error("IMM_W must not exceed DATA_W");
      end
      if (IMM_LSB + IMM_W > INSTR_W) begin : g_bad_imm_pos
         $error("immediate field leaves the instruction word");
      end
      if (REG_W != 4) begin : g_bad_reg
         $error("register fields are one nibble wide");
      end
      if (PC_REG == 0 || PC_REG > PC_MAX) begin : g_bad_pc
         $error("PC_REG must name a nonzero register");
      end
   endgenerate

   op_kind_e kind;

   sd_opclass u_class (
      .instr_i (instr_i),
      .kind_o  (kind)
   );

   always_comb begin
      rd_en_o  = (kind == OPK_RD);
      wr_en_o  = (kind == OPK_WR);
      push_o   = (kind == OPK_PUSH) || (kind == OPK_PUSHI);
      pop_o    = (kind == OPK_POP);
      imm_en_o = (kind == OPK_PUSHI);
   end

   sd_regfield #(.REG_W(REG_W), .PC_REG(PC_REG)) u_regs (
      .kind_i    (kind),
      .src_fld_i (instr_i[SRC_LSB +: REG_W]),
      .dst_fld_i (instr_i[DST_LSB +: REG_W]),
      .src_oe_o  (src_oe_o),
      .src_sel_o (src_sel_o),
      .dst_ld_o  (dst_ld_o),
      .dst_sel_o (dst_sel_o),
      .pc_hit_o  (pc_pop_o)
   );

   sd_immext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_imm (
      .en_i  (imm_en_o),
      .fld_i (instr_i[IMM_LSB +: IMM_W]),
      .imm_o (imm_o)
   );
endmodule

// File: rtl/sd_stackmem_decode_chk.sv
module sd_stackmem_decode_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned REG_W  = 4,
   parameter int unsigned PC_REG = 1
) (
   input logic [15:0]       instr_i,
   input logic              rd_en_o,
   input logic              wr_en_o,
   input logic              push_o,
   input logic              pop_o,
   input logic              src_oe_o,
   input logic [REG_W-1:0]  src_sel_o,
   input logic              dst_ld_o,
   input logic [REG_W-1:0]  dst_sel_o,
   input logic              imm_en_o,
   input logic [DATA_W-1:0] imm_o,
   input logic              pc_pop_o
);
   always_comb begin
      if (!$isunknown(instr_i)) begin
         // R9
         strobe_excl_chk : assert ($countones({rd_en_o, wr_en_o, push_o, pop_o}) <= 1);
         // R1
         mem_rd_word_chk : assert (!rd_en_o || instr_i == 16'h7000);
         // R2
         mem_wr_word_chk : assert (!wr_en_o || instr_i == 16'h7100);
         // R3
         push_src_chk : assert (!src_oe_o || (push_o && src_sel_o == instr_i[7:4] && src_sel_o != '0));
         // R4
         pop_dst_chk : assert (!dst_ld_o || (pop_o && dst_sel_o == instr_i[3:0] && dst_sel_o != '0));
         // R5
         imm_value_chk : assert (!imm_en_o || (push_o && !src_oe_o && imm_o == DATA_W'(instr_i[11:4])));
         // R6
         pc_pop_chk : assert (!pc_pop_o || (dst_ld_o && dst_sel_o == REG_W'(PC_REG)));
         // R9
         idle_zero_chk : assert ((src_oe_o || src_sel_o == '0) && (dst_ld_o || dst_sel_o == '0)
                                 && (imm_en_o || imm_o == '0));
      end
   end
endmodule

bind sd_stackmem_decode sd_stackmem_decode_chk #(
   .DATA_W (DATA_W),
   .REG_W  (REG_W),
   .PC_REG (PC_REG)
) u_chk (
   .instr_i   (instr_i),
   .rd_en_o   (rd_en_o),
   .wr_en_o   (wr_en_o),
   .push_o    (push_o),
   .pop_o     (pop_o),
   .src_oe_o  (src_oe_o),
   .src_sel_o (src_sel_o),
   .dst_ld_o  (dst_ld_o),
   .dst_sel_o (dst_sel_o),
   .imm_en_o  (imm_en_o),
   .imm_o     (imm_o),
   .pc_pop_o  (pc_pop_o)
);

// File: tb/tb_sd_stackmem_decode.sv
module tb_sd_stackmem_decode;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] instr = 16'h0000;

   logic        rd_en, wr_en, push, pop, src_oe, dst_ld, imm_en, pc_pop;
   logic [3:0]  src_sel, dst_sel;
   logic [15:0] imm;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   sd_stackmem_decode dut (
      .instr_i   (instr),
      .rd_en_o   (rd_en),
      .wr_en_o   (wr_en),
      .push_o    (push),
      .pop_o     (pop),
      .src_oe_o  (src_oe),
      .src_sel_o (src_sel),
      .dst_ld_o  (dst_ld),
      .dst_sel_o (dst_sel),
      .imm_en_o  (imm_en),
      .imm_o     (imm),
      .pc_pop_o  (pc_pop)
   );

   // expected layout: rd wr push pop src_oe src_sel dst_ld dst_sel imm_en imm pc
   typedef struct packed {
      logic [15:0] instr;
      logic        rd;
      logic        wr;
      logic        push;
      logic        pop;
      logic        soe;
      logic [3:0]  ssel;
      logic        dld;
      logic [3:0]  dsel;
      logic        ien;
      logic [15:0] imm;
      logic        pc;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t TBL [NV] = '{
      '{16'h7000, 1'b1,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}, // R1
      '{16'h7100, 1'b0,1'b1,1'b0,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}, // R2
      '{16'h8030, 1'b0,1'b0,1'b1,1'b0, 1'b1,4'h3, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}, // R3
      '{16'h80F7, 1'b0,1'b0,1'b1,1'b0, 1'b1,4'hF, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}, // R3
      '{16'h8000, 1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}, // R7
      '{16'h9005, 1'b0,1'b0,1'b0,1'b1, 1'b0,4'h0, 1'b1,4'h5, 1'b0,16'h0000, 1'b0}, // R4
      '{16'h9001, 1'b0,1'b0,1'b0,1'b1, 1'b0,4'h0, 1'b1,4'h1, 1'b0,16'h0000, 1'b1}, // R6
      '{16'h900F, 1'b0,1'b0,1'b0,1'b1, 1'b0,4'h0, 1'b1,4'hF, 1'b0,16'h0000, 1'b0}, // R4
      '{16'h9000, 1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}, // R7
      '{16'hA5A0, 1'b0,1'b0,1'b1,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,16'h005A, 1'b0}, // R5
      '{16'hAFF9, 1'b0,1'b0,1'b1,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,16'h00FF, 1'b0}, // R5
      '{16'hA000, 1'b0,1'b0,1'b1,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,16'h0000, 1'b0}, // R5
      '{16'h7001, 1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}, // R8
      '{16'h7200, 1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}, // R8
      '{16'h8130, 1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}, // R8
      '{16'h9010, 1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}, // R8
      '{16'h0000, 1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}, // R8
      '{16'hFFFF, 1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}, // R8
      '{16'h1234, 1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,16'h0000, 1'b0}  // R8
   };

   function automatic logic [31:0] observed();
      return {rd_en, wr_en, push, pop, src_oe, src_sel, dst_ld, dst_sel, imm_en, imm, pc_pop};
   endfunction

   task automatic check(input string req, input logic [15:0] w, input logic [31:0] exp);
      logic [31:0] act;
      act = observed();
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s instr=%h actual=%h expected=%h", req, w, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] w);
      @(negedge clk);
      instr = w;
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // reset state: idle word drives nothing (R8)
      apply(16'h0000);
      check("R8", 16'h0000, 32'h0);

      for (int i = 0; i < NV; i++) begin
         apply(TBL[i].instr);
         check("R1..R9 table", TBL[i].instr, TBL[i][31:0]);
      end

      // R3: low nibble of a push is ignored
      for (int n = 0; n < 16; n++) begin
         apply({12'h807, 4'(n)});
         check("R3", instr, {4'b0010, 1'b1, 4'h7, 1'b0, 4'h0, 1'b0, 16'h0, 1'b0});
      end

      // R5: low nibble of an immediate push is ignored
      for (int n = 0; n < 16; n++) begin
         apply({12'hAC3, 4'(n)});
         check("R5", instr, {4'b0010, 1'b0, 4'h0, 1'b0, 4'h0, 1'b1, 16'h00C3, 1'b0});
      end

      // R4 R6 R7: every destination number
      for (int d = 0; d < 16; d++) begin
         logic [31:0] e;
         apply({12'h900, 4'(d)});
         if (d == 0) e = 32'h0;
         else e = {4'b0001, 1'b0, 4'h0, 1'b1, 4'(d), 1'b0, 16'h0, (d == 1)};
         check(d == 1 ? "R6" : (d == 0 ? "R7" : "R4"), instr, e);
      end

      // R1 R2 R9: back-to-back memory words
      apply(16'h7100);
      check("R2", instr, {4'b0100, 28'h0});
      apply(16'h7000);
      check("R1", instr, {4'b1000, 28'h0});

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule